// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This unit watches the per-element results of a vector loop as they come back in ascending element order. It decides where the loop must stop and what the shortened vector length becomes. A start pulse arms it with the current length and a fail-first configuration. It then accepts one element per `elem_valid` strobe and drives a write enable for that element's result. When a stop condition occurs, it latches the truncated length and squashes everything after it. The memory system and the ALU that produce the fault flags and condition nibbles lie outside the unit.

There are two truncation rules.

- **Memory-access mode.** Element 0 faults in the ordinary way and raises an exception. A fault on any later element instead cuts the length back to that element's index. This mode never yields a length of zero.
- **Condition-driven mode.** One chosen bit of each element's 4-bit condition nibble is compared against an invert bit. A match ends the loop. The cut either includes or excludes the failing element. The cut can reach zero. A condition-only option suppresses every result write.

Controller states:

| State | Meaning |
|---|---|
| `ST_IDLE` | After reset |
| `ST_RUN` | Accepting elements |
| `ST_TRUNC` | Stopped on a test failure or a later-element fault |
| `ST_FAULT` | Stopped on an element-0 fault, exception raised |
| `ST_FULL` | Every element passed, or the armed length was zero |

Transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| `arm` | any state | `ST_RUN`, or `ST_FULL` when the length is 0 | `start` pulse |
| `pass` | `ST_RUN` | `ST_RUN` | Passing element that is not the last |
| `finish` | `ST_RUN` | `ST_FULL` | Passing last element |
| `cut` | `ST_RUN` | `ST_TRUNC` | Failing element |
| `trap` | `ST_RUN` | `ST_FAULT` | Element-0 fault in memory-access mode |

Top module: `ffirst_trunc`

## Requirements
- R1: A `start` pulse captures the configuration and sets `new_vl` to `cfg_vl` with `stop`, `done` and `raise_exc` low. With `cfg_vl` = 0 the unit goes directly to done.
- R2: In memory-access mode (`cfg_mode` = 0), a fault on element 0 has three effects on the next cycle. `raise_exc` goes high for exactly one cycle. `stop` and `done` go high. `new_vl` keeps the armed length. That element's write enable stays low.
- R3: In memory-access mode, a fault on element i ≥ 1 sets `new_vl` to i and raises `stop` and `done` without `raise_exc`. That element's write enable stays low.
- R4: In memory-access mode, a truncation never produces `new_vl` = 0.
- R5: In condition-driven mode (`cfg_mode` = 1), the tested bit is `elem_cond[cfg_sel]`, where `cfg_sel` 0..3 picks bit 0..3. The element fails when that bit equals `cfg_inv`.
- R6: A condition-driven failure at element i sets `new_vl` to i when inclusive counting is in effect clear, and to i+1 when it is set. The failing element's write enable is high only when inclusive counting is in effect.
- R7: Inclusive counting (`cfg_vli`) is in effect only when `cfg_rc` = 0. With `cfg_rc` = 1 it behaves as clear.
- R8: A condition-driven failure on element 0 with inclusive counting clear gives `new_vl` = 0.
- R9: With `cfg_rc1` = 1 in condition-driven mode, `wr_en` is never asserted. In memory-access mode `cfg_rc1` has no effect.
- R10: When no element fails, `new_vl` stays at the armed length. `done` rises on the cycle after element VL-1 is accepted, and `stop` stays low.
- R11: After `stop` or `done`, further elements are ignored until the next `start`. `wr_en` stays low and `new_vl`, `stop` and `done` hold.
- R12: A passing element accepted while running drives `wr_en` high in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm pulse; captures all cfg_* inputs |
| cfg_mode | input | 1 | 0 = memory-access fail-first, 1 = condition-driven |
| cfg_vl | input | VL_W | Vector length to process |
| cfg_sel | input | 2 | Condition nibble bit to test |
| cfg_inv | input | 1 | Bit value that counts as failure |
| cfg_vli | input | 1 | Inclusive counting request |
| cfg_rc | input | 1 | Record-form flag; disables inclusive counting |
| cfg_rc1 | input | 1 | Condition-only: store no results |
| elem_valid | input | 1 | Next element in order is presented |
| elem_fault | input | 1 | Element would fault (memory-access mode) |
| elem_cond | input | 4 | Element condition nibble (condition-driven mode) |
| wr_en | output | 1 | Write the presented element's result |
| new_vl | output | VL_W | Resulting vector length |
| stop | output | 1 | Loop truncated or trapped; later elements squashed |
| done | output | 1 | Loop finished by any route |
| raise_exc | output | 1 | One-cycle exception request for an element-0 fault |

## Verification
The bench builds the unit with `VL_W` = 4, so armed lengths run only up to 15. This lets a run through all fifteen elements reach `ST_FULL` in a few cycles. It also places the zero-length arm and the last-element corner close together. With that narrow width, the inclusive cut on the final index (i+1 = VL) and the exclusive cut at element 0 both sit at the ends of the length field. Any wrap or off-by-one there shows directly on `new_vl`.

// File: rtl/ffirst_pkg.sv
package ffirst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_TRUNC = 3'd2,
        ST_FAULT = 3'd3,
        ST_FULL  = 3'd4
    } ff_state_t;

    typedef enum logic {
        MODE_MEM  = 1'b0,
        MODE_COND = 1'b1
    } ff_mode_t;

    typedef struct packed {
        ff_mode_t   mode;
        logic [1:0] sel;
        logic       inv;
        logic       incl;   // inclusive counting after the record-form gate
        logic       rc1;
    } ff_cfg_t;

endpackage

// File: rtl/ffirst_elem_eval.sv
module ffirst_elem_eval
    import ffirst_pkg::*;
#(
    parameter int VL_W = 7
) (
    input  ff_cfg_t         cfg,
    input  logic [VL_W-1:0] idx,
    input  logic            fault,
    input  logic [3:0]      cond,
    output logic            fail,
    output logic            exc_req,
    output logic            keep,
    output logic [VL_W-1:0] cut_vl
);

    logic hit;

    always_comb begin
        hit     = (cond[cfg.sel] == cfg.inv);
        fail    = 1'b0;
        exc_req = 1'b0;
        keep    = 1'b0;
        cut_vl  = idx;
        unique case (cfg.mode)
            MODE_MEM: begin
                fail    = fault;
                exc_req = fault && (idx == '0);
                keep    = !fault;
                cut_vl  = idx;
            end
            MODE_COND: begin
                fail    = hit;
                keep    = !cfg.rc1 && (!hit || cfg.incl);
                cut_vl  = idx + {{(VL_W-1){1'b0}}, cfg.incl};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ffirst_idx_ctr.sv
module ffirst_idx_ctr #(
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    output logic [VL_W-1:0] idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx <= '0;
        else if (clear) idx <= '0;
        else if (step)  idx <= idx + 1'b1;
    end

endmodule

// File: rtl/ffirst_trunc.sv
module ffirst_trunc
    import ffirst_pkg::*;
#(
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cfg_mode,
    input  logic [VL_W-1:0] cfg_vl,
    input  logic [1:0]      cfg_sel,
    input  logic            cfg_inv,
    input  logic            cfg_vli,
    input  logic            cfg_rc,
    input  logic            cfg_rc1,
    input  logic            elem_valid,
    input  logic            elem_fault,
    input  logic [3:0]      elem_cond,
    output logic            wr_en,
    output logic [VL_W-1:0] new_vl,
    output logic            stop,
    output logic            done,
    output logic            raise_exc
);

    ff_state_t       state, state_nx;
    ff_cfg_t         cfg_q;
    logic [VL_W-1:0] vl_q, new_vl_q, idx;
    logic            exc_q;
    logic            accept, last;
    logic            e_fail, e_exc, e_keep;
    logic [VL_W-1:0] e_cut;

    assign accept = elem_valid && (state == ST_RUN) && !start;
    assign last   = (idx == vl_q - 1'b1);

    ffirst_idx_ctr #(.VL_W(VL_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (accept),
        .idx   (idx)
    );

    ffirst_elem_eval #(.VL_W(VL_W)) u_eval (
        .cfg     (cfg_q),
        .idx     (idx),
        .fault   (elem_fault),
        .cond    (elem_cond),
        .fail    (e_fail),
        .exc_req (e_exc),
        .keep    (e_keep),
        .cut_vl  (e_cut)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = (cfg_vl == '0) ? ST_FULL : ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (accept) begin
                        if (e_exc)       state_nx = ST_FAULT;
                        else if (e_fail) state_nx = ST_TRUNC;
                        else if (last)   state_nx = ST_FULL;
                    end
                end
                ST_IDLE, ST_TRUNC, ST_FAULT, ST_FULL: state_nx = state;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            vl_q     <= '0;
            new_vl_q <= '0;
            exc_q    <= 1'b0;
        end else begin
            state <= state_nx;
            exc_q <= accept && e_exc;
            if (start) begin
                cfg_q    <= '{mode: ff_mode_t'(cfg_mode), sel: cfg_sel, inv: cfg_inv,
                              incl: cfg_vli && !cfg_rc, rc1: cfg_rc1};
                vl_q     <= cfg_vl;
                new_vl_q <= cfg_vl;
            end else if (accept && e_fail && !e_exc) begin
                new_vl_q <= e_cut;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en     = accept && e_keep;
        new_vl    = new_vl_q;
        raise_exc = exc_q;
        stop      = (state == ST_TRUNC) || (state == ST_FAULT);
        done      = stop || (state == ST_FULL);
    end

    a_r4_mem_cut_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRUNC && cfg_q.mode == MODE_MEM) |-> (new_vl != '0));

    a_r2_exc_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_exc && !start) |=> !raise_exc);

    a_r2_exc_means_fault: assert property (@(posedge clk) disable iff (!rst_n)
        raise_exc |-> (stop && new_vl == vl_q));

    a_r9_rc1_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_COND && cfg_q.rc1) |-> !wr_en);

    a_r11_frozen_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(new_vl) && done && !wr_en));

    a_r6_cut_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (new_vl <= vl_q));

endmodule

// File: tb/ffirst_trunc_test.sv
module ffirst_trunc_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, cfg_mode = 1'b0, cfg_inv = 1'b0, cfg_vli = 1'b0;
    logic         cfg_rc = 1'b0, cfg_rc1 = 1'b0;
    logic [W-1:0] cfg_vl = '0;
    logic [1:0]   cfg_sel = '0;
    logic         elem_valid = 1'b0, elem_fault = 1'b0;
    logic [3:0]   elem_cond = '0;
    logic         wr_en, stop, done, raise_exc;
    logic [W-1:0] new_vl;

    int checks = 0, errors = 0, cycles = 0;
    string cur = "R1";

    // reference model state: 0 idle, 1 run, 2 cut, 3 trap, 4 full
    int m_state = 0, m_idx = 0, m_vl = 0, m_new = 0, m_exc = 0;
    int m_mode = 0, m_sel = 0, m_inv = 0, m_incl = 0, m_rc1 = 0;

    always #10 clk = ~clk;

    ffirst_trunc #(.VL_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_vl(cfg_vl), .cfg_sel(cfg_sel), .cfg_inv(cfg_inv), .cfg_vli(cfg_vli),
        .cfg_rc(cfg_rc), .cfg_rc1(cfg_rc1), .elem_valid(elem_valid),
        .elem_fault(elem_fault), .elem_cond(elem_cond), .wr_en(wr_en),
        .new_vl(new_vl), .stop(stop), .done(done), .raise_exc(raise_exc)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur, what, act, exp);
        end
    endtask

    function automatic int m_keep();
        int hit;
        if (m_mode == 0) return elem_fault ? 0 : 1;
        hit = (((elem_cond >> m_sel) & 1) == m_inv) ? 1 : 0;
        return (m_rc1 == 0 && (hit == 0 || m_incl == 1)) ? 1 : 0;
    endfunction

    // one clock: check combinational write enable, advance model, check registers
    task automatic cyc();
        int acc, hit;
        #1;
        acc = (m_state == 1 && elem_valid && !start) ? 1 : 0;
        chk("wr_en", int'(wr_en), acc ? m_keep() : 0);
        @(posedge clk);
        m_exc = 0;
        if (start) begin
            m_mode = cfg_mode; m_sel = cfg_sel; m_inv = cfg_inv;
            m_incl = (cfg_vli && !cfg_rc) ? 1 : 0; m_rc1 = cfg_rc1;
            m_vl = cfg_vl; m_new = cfg_vl; m_idx = 0;
            m_state = (cfg_vl == 0) ? 4 : 1;
        end else if (acc) begin
            if (m_mode == 0) begin
                if (elem_fault && m_idx == 0) begin m_state = 3; m_exc = 1; end
                else if (elem_fault) begin m_state = 2; m_new = m_idx; end
                else if (m_idx == m_vl - 1) m_state = 4;
            end else begin
                hit = (((elem_cond >> m_sel) & 1) == m_inv) ? 1 : 0;
                if (hit) begin m_state = 2; m_new = m_idx + m_incl; end
                else if (m_idx == m_vl - 1) m_state = 4;
            end
            m_idx++;
        end
        @(negedge clk);
        chk("new_vl", int'(new_vl), m_new);
        chk("stop", int'(stop), (m_state == 2 || m_state == 3) ? 1 : 0);
        chk("done", int'(done), (m_state >= 2) ? 1 : 0);
        chk("raise_exc", int'(raise_exc), m_exc);
    endtask

    task automatic arm(input int mode, input int vl, input int sel, input int inv,
                       input int vli, input int rc, input int rc1);
        start = 1'b1; cfg_mode = mode[0]; cfg_vl = vl[W-1:0]; cfg_sel = sel[1:0];
        cfg_inv = inv[0]; cfg_vli = vli[0]; cfg_rc = rc[0]; cfg_rc1 = rc1[0];
        elem_valid = 1'b0;
        cyc();
        start = 1'b0;
    endtask

    task automatic el(input int fault, input int cond);
        elem_valid = 1'b1; elem_fault = fault[0]; elem_cond = cond[3:0];
        cyc();
        elem_valid = 1'b0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        cur = "R1";
        chk("reset stop", int'(stop), 0);
        chk("reset done", int'(done), 0);
        chk("reset new_vl", int'(new_vl), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R12: memory mode, no faults, length 4
        cur = "R10";
        arm(0, 4, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) el(0, 0);
        // R11: ignored after done
        cur = "R11";
        el(1, 0); el(0, 0);

        // R2: element-0 fault
        cur = "R2";
        arm(0, 5, 0, 0, 0, 0, 0);
        el(1, 0);
        cyc();

        // R3 / R4: fault at element 2, rc1 set has no effect in memory mode (R9)
        cur = "R3";
        arm(0, 5, 0, 0, 0, 0, 1);
        el(0, 0); el(0, 0); el(1, 0);
        cur = "R11";
        el(0, 0); el(1, 0);

        // R5 / R6: condition bit 2, inv 0, exclusive, fail at 2
        cur = "R5";
        arm(1, 6, 2, 0, 0, 0, 0);
        el(0, 4'b0100); el(0, 4'b1111); el(0, 4'b1011);

        // R6: bit 1, inv 1, inclusive, fail at 3
        cur = "R6";
        arm(1, 8, 1, 1, 1, 0, 0);
        el(0, 4'b0000); el(0, 4'b1101); el(0, 4'b0001); el(0, 4'b0010);

        // R6: inclusive cut at final index gives VL
        arm(1, 3, 0, 1, 1, 0, 0);
        el(0, 0); el(0, 0); el(0, 1);

        // R7: inclusive requested with rc set -> exclusive
        cur = "R7";
        arm(1, 7, 3, 0, 1, 1, 0);
        el(0, 4'b1000); el(0, 4'b0111);

        // R8: element 0 fails, exclusive -> 0
        cur = "R8";
        arm(1, 9, 0, 1, 0, 0, 0);
        el(0, 4'b0001);

        // R9: rc1 in condition mode, no failure
        cur = "R9";
        arm(1, 3, 0, 1, 0, 0, 1);
        el(0, 0); el(0, 0); el(0, 0);

        // R10: longest length, R1: zero length
        cur = "R10";
        arm(0, 15, 0, 0, 0, 0, 0);
        for (int i = 0; i < 15; i++) el(0, 0);
        cur = "R1";
        arm(1, 0, 0, 0, 0, 0, 0);
        el(0, 0);

        // R12: gaps in the strobe
        cur = "R12";
        arm(1, 2, 3, 1, 0, 0, 0);
        cyc(); el(0, 0); cyc(); el(0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule